// File: doc/BRIEF.md
# Configurable Pipelined Multiplier Element

This block multiplies an operand A of `A_W` bits by an operand B of `B_W` bits and returns the full product of `A_W+B_W` bits. Each operand carries its own signedness flag, so either one can be read as two's complement or as unsigned. The element only multiplies. It has no adder, accumulator, rounding or saturation after the multiplier.

There are four register stages: one input register per operand, a pipeline register after the multiplier, and an output register. Each stage is kept or removed by a parameter. Each register group takes its clock enable and its synchronous reset from one of four shared lines, and the choice of line is set by a parameter.

Each operand input register can load either from its parallel input or from a cascade input. That register also drives a cascade output. A row of elements can therefore pass operands from one to the next as a delay line. All logic runs on a single clock.

Top module: `mulel_top`

## Requirements
- R1: `prod` equals the low `A_W+B_W` bits of A×B. A is sign-extended when `a_sign`=1 and zero-extended when `a_sign`=0. B follows the same rule with `b_sign`.
- R2: With every stage bypassed, `prod` is a combinational function of the inputs. Each enabled stage (`IN_REG_A` or `PIPE_REG` or `OUT_REG` on the A path, `IN_REG_B` or `PIPE_REG` or `OUT_REG` on the B path) adds exactly one clock of latency to that operand's path.
- R3: Each signedness flag is registered in the same input register as its operand. A product is therefore always formed with the flag that arrived together with its operand.
- R4: `SRC_A`/`SRC_B` select the input register source: 0 selects the parallel input and 1 selects the cascade input. The unselected input has no effect.
- R5: A cascade output carries the operand value held in that operand's input register. When the input register is bypassed, the cascade output carries the selected source combinationally.
- R6: A register group loads only when `ce[CE_SEL_x]` is 1. When that line is 0, the group holds its value. Clock enable lines that the group does not select have no effect on it.
- R7: When `rst[RST_SEL_x]` is 1 at a clock edge, the group clears to zero. This happens even if its clock enable is 0. Reset lines that the group does not select have no effect on it.
- R8: After reset, `prod`, `a_cas_out` and `b_cas_out` of a fully registered element read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| ce | input | 4 | Candidate clock enable lines |
| rst | input | 4 | Candidate synchronous reset lines, active high |
| a_in | input | A_W | Parallel operand A |
| a_sign | input | 1 | 1 = treat A as two's complement |
| b_in | input | B_W | Parallel operand B |
| b_sign | input | 1 | 1 = treat B as two's complement |
| a_cas_in | input | A_W | Cascade input for operand A |
| b_cas_in | input | B_W | Cascade input for operand B |
| a_cas_out | output | A_W | Cascade output of operand A |
| b_cas_out | output | B_W | Cascade output of operand B |
| prod | output | A_W+B_W | Product |

## Verification
The hardest situation to reach is uneven latency, where A and B cross different numbers of registers. In that case the product combines operands and flags from different input cycles, and the flags have to stay attached to their own operands. The bench builds all sixteen stage combinations side by side and walks a table whose signedness changes on every row. Each output is checked against a model that offsets the A and B histories separately. A second element is fed through the cascade path, using a different enable and reset line. This allows hold and reset priority to be shown on one element while its neighbour keeps running.

// File: rtl/mulel_pkg.sv
package mulel_pkg;
  localparam int NUM_CTRL = 4;

  typedef enum logic {
    SRC_PARALLEL = 1'b0,
    SRC_CASCADE  = 1'b1
  } src_e;
endpackage

// File: rtl/mulel_stage.sv
// One optional register group with selectable enable and reset line.
module mulel_stage
  import mulel_pkg::*;
#(
  parameter int W       = 8,
  parameter bit EN      = 1'b1,
  parameter int CE_SEL  = 0,
  parameter int RST_SEL = 0
) (
  input  logic                clk,
  input  logic [NUM_CTRL-1:0] ce_vec,
  input  logic [NUM_CTRL-1:0] rst_vec,
  input  logic [W-1:0]        d,
  output logic [W-1:0]        q
);
  logic ce_g;
  logic rst_g;
  logic unused_ctl;

  assign ce_g       = ce_vec[CE_SEL];
  assign rst_g      = rst_vec[RST_SEL];
  assign unused_ctl = ^{ce_vec, rst_vec};

  generate
    if (EN) begin : g_reg
      logic [W-1:0] q_r;
      always_ff @(posedge clk) begin
        if (rst_g)     q_r <= '0;
        else if (ce_g) q_r <= d;
      end
      assign q = q_r;

      // R7
      rst_clr_chk: assert property (@(posedge clk) disable iff (rst_g)
        $past(rst_g) |-> (q == '0));
      // R6
      hold_chk: assert property (@(posedge clk) disable iff (rst_g)
        !ce_g |=> $stable(q));
      // R6
      load_chk: assert property (@(posedge clk) disable iff (rst_g)
        ce_g |=> (q == $past(d)));
    end else begin : g_byp
      logic unused_clk;
      assign unused_clk = clk;
      assign q = d;
    end
  endgenerate
endmodule

// File: rtl/mulel_opreg.sv
// Operand input register: source mux, flag kept with data, cascade output.
module mulel_opreg
  import mulel_pkg::*;
#(
  parameter int   W       = 8,
  parameter bit   EN      = 1'b1,
  parameter src_e SRC     = SRC_PARALLEL,
  parameter int   CE_SEL  = 0,
  parameter int   RST_SEL = 0
) (
  input  logic                clk,
  input  logic [NUM_CTRL-1:0] ce_vec,
  input  logic [NUM_CTRL-1:0] rst_vec,
  input  logic [W-1:0]        par_in,
  input  logic [W-1:0]        cas_in,
  input  logic                sign_in,
  output logic [W-1:0]        opnd,
  output logic                sign_out,
  output logic [W-1:0]        cas_out
);
  logic [W-1:0] src_sel;
  logic [W:0]   held;
  logic         ld_now;
  logic         clr_now;

  generate
    if (SRC == SRC_CASCADE) begin : g_cas
      logic [W-1:0] unused_par;
      assign unused_par = par_in;
      assign src_sel    = cas_in;
    end else begin : g_par
      logic [W-1:0] unused_cas;
      assign unused_cas = cas_in;
      assign src_sel    = par_in;
    end
  endgenerate

  mulel_stage #(
    .W(W + 1), .EN(EN), .CE_SEL(CE_SEL), .RST_SEL(RST_SEL)
  ) u_hold (
    .clk(clk), .ce_vec(ce_vec), .rst_vec(rst_vec),
    .d({sign_in, src_sel}), .q(held)
  );

  assign opnd     = held[W-1:0];
  assign sign_out = held[W];
  assign cas_out  = held[W-1:0];
  assign ld_now   = ce_vec[CE_SEL];
  assign clr_now  = rst_vec[RST_SEL];

  generate
    if (EN) begin : g_chk
      // R3
      sign_track_chk: assert property (@(posedge clk) disable iff (clr_now)
        ld_now |=> (sign_out == $past(sign_in)));
      // R4
      src_pick_chk: assert property (@(posedge clk) disable iff (clr_now)
        ld_now |=> (cas_out == $past((SRC == SRC_CASCADE) ? cas_in : par_in)));
    end
  endgenerate
endmodule

// File: rtl/mulel_core.sv
// Combinational multiplier with per-operand signedness.
module mulel_core #(
  parameter int A_W = 8,
  parameter int B_W = 8,
  localparam int P_W = A_W + B_W
) (
  input  logic [A_W-1:0] a,
  input  logic           a_sgn,
  input  logic [B_W-1:0] b,
  input  logic           b_sgn,
  output logic [P_W-1:0] p
);
  function automatic logic [P_W-1:0] mixed_mul(
    input logic [A_W-1:0] x, input logic xs,
    input logic [B_W-1:0] y, input logic ys);
    logic [A_W:0]   xe;
    logic [B_W:0]   ye;
    logic [P_W+1:0] full;
    xe   = {xs & x[A_W-1], x};
    ye   = {ys & y[B_W-1], y};
    full = $signed({{(B_W+1){xe[A_W]}}, xe}) * $signed({{(A_W+1){ye[B_W]}}, ye});
    return full[P_W-1:0];
  endfunction

  assign p = mixed_mul(a, a_sgn, b, b_sgn);

  // R1
  always_comb begin
    zero_chk: assert (!((a == '0 || b == '0) && p != '0));
  end
endmodule

// File: rtl/mulel_top.sv
module mulel_top
  import mulel_pkg::*;
#(
  parameter int   A_W         = 8,
  parameter int   B_W         = 8,
  parameter bit   IN_REG_A    = 1'b1,
  parameter bit   IN_REG_B    = 1'b1,
  parameter bit   PIPE_REG    = 1'b1,
  parameter bit   OUT_REG     = 1'b1,
  parameter src_e SRC_A       = SRC_PARALLEL,
  parameter src_e SRC_B       = SRC_PARALLEL,
  parameter int   CE_SEL_A    = 0,
  parameter int   CE_SEL_B    = 0,
  parameter int   CE_SEL_P    = 0,
  parameter int   CE_SEL_O    = 0,
  parameter int   RST_SEL_A   = 0,
  parameter int   RST_SEL_B   = 0,
  parameter int   RST_SEL_P   = 0,
  parameter int   RST_SEL_O   = 0,
  localparam int  P_W         = A_W + B_W
) (
  input  logic                clk,
  input  logic [NUM_CTRL-1:0] ce,
  input  logic [NUM_CTRL-1:0] rst,
  input  logic [A_W-1:0]      a_in,
  input  logic                a_sign,
  input  logic [B_W-1:0]      b_in,
  input  logic                b_sign,
  input  logic [A_W-1:0]      a_cas_in,
  input  logic [B_W-1:0]      b_cas_in,
  output logic [A_W-1:0]      a_cas_out,
  output logic [B_W-1:0]      b_cas_out,
  output logic [P_W-1:0]      prod
);
  logic [A_W-1:0] a_op;
  logic [B_W-1:0] b_op;
  logic           a_sg;
  logic           b_sg;
  logic [P_W-1:0] mul_raw;
  logic [P_W-1:0] mul_piped;

  mulel_opreg #(
    .W(A_W), .EN(IN_REG_A), .SRC(SRC_A), .CE_SEL(CE_SEL_A), .RST_SEL(RST_SEL_A)
  ) u_opa (
    .clk(clk), .ce_vec(ce), .rst_vec(rst), .par_in(a_in), .cas_in(a_cas_in),
    .sign_in(a_sign), .opnd(a_op), .sign_out(a_sg), .cas_out(a_cas_out)
  );

  mulel_opreg #(
    .W(B_W), .EN(IN_REG_B), .SRC(SRC_B), .CE_SEL(CE_SEL_B), .RST_SEL(RST_SEL_B)
  ) u_opb (
    .clk(clk), .ce_vec(ce), .rst_vec(rst), .par_in(b_in), .cas_in(b_cas_in),
    .sign_in(b_sign), .opnd(b_op), .sign_out(b_sg), .cas_out(b_cas_out)
  );

  mulel_core #(.A_W(A_W), .B_W(B_W)) u_core (
    .a(a_op), .a_sgn(a_sg), .b(b_op), .b_sgn(b_sg), .p(mul_raw)
  );

  mulel_stage #(
    .W(P_W), .EN(PIPE_REG), .CE_SEL(CE_SEL_P), .RST_SEL(RST_SEL_P)
  ) u_pipe (
    .clk(clk), .ce_vec(ce), .rst_vec(rst), .d(mul_raw), .q(mul_piped)
  );

  mulel_stage #(
    .W(P_W), .EN(OUT_REG), .CE_SEL(CE_SEL_O), .RST_SEL(RST_SEL_O)
  ) u_out (
    .clk(clk), .ce_vec(ce), .rst_vec(rst), .d(mul_piped), .q(prod)
  );
endmodule

// File: tb/mulel_top_tb.sv
module mulel_top_tb;
  import mulel_pkg::*;

  localparam int NV = 24;
  // {a_sign, b_sign, a, b}
  localparam logic [17:0] VEC [NV] = '{
    {2'b00, 8'h03, 8'h05}, {2'b11, 8'hFF, 8'hFF}, {2'b00, 8'hFF, 8'hFF},
    {2'b10, 8'h80, 8'h02}, {2'b01, 8'h02, 8'h80}, {2'b11, 8'h80, 8'h80},
    {2'b00, 8'h80, 8'h80}, {2'b11, 8'h7F, 8'h81}, {2'b10, 8'hFE, 8'h7F},
    {2'b01, 8'h7F, 8'hFE}, {2'b00, 8'h00, 8'hC3}, {2'b11, 8'h01, 8'hFF},
    {2'b10, 8'hC0, 8'hC0}, {2'b01, 8'hC0, 8'hC0}, {2'b11, 8'hC0, 8'hC0},
    {2'b00, 8'hC0, 8'hC0}, {2'b11, 8'h12, 8'h34}, {2'b10, 8'h9A, 8'h0F},
    {2'b01, 8'h0F, 8'h9A}, {2'b00, 8'hAA, 8'h55}, {2'b11, 8'hAA, 8'h55},
    {2'b10, 8'hFF, 8'h01}, {2'b01, 8'h01, 8'hFF}, {2'b11, 8'h7F, 8'h7F}
  };

  logic       clk;
  logic [3:0] ce;
  logic [3:0] rst;
  logic [7:0] a_i, b_i;
  logic       sa_i, sb_i;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [15:0] dut_p;
  logic [7:0]  dut_acas, dut_bcas;
  logic [15:0] cas_p;
  logic [7:0]  cas_acas, cas_bcas;
  logic [15:0] pv  [16];
  logic [7:0]  pca [16];
  logic [7:0]  pcb [16];

  initial clk = 1'b0;
  always #5 clk = ~clk;

  mulel_top u_dut (
    .clk(clk), .ce(ce), .rst(rst), .a_in(a_i), .a_sign(sa_i), .b_in(b_i),
    .b_sign(sb_i), .a_cas_in(8'h00), .b_cas_in(8'h00),
    .a_cas_out(dut_acas), .b_cas_out(dut_bcas), .prod(dut_p)
  );

  // Cascade neighbour on enable line 2 and reset line 3.
  mulel_top #(
    .SRC_A(SRC_CASCADE), .SRC_B(SRC_CASCADE),
    .CE_SEL_A(2), .CE_SEL_B(2), .CE_SEL_P(2), .CE_SEL_O(2),
    .RST_SEL_A(3), .RST_SEL_B(3), .RST_SEL_P(3), .RST_SEL_O(3)
  ) u_cas (
    .clk(clk), .ce(ce), .rst(rst), .a_in(a_i), .a_sign(1'b0), .b_in(b_i),
    .b_sign(1'b0), .a_cas_in(dut_acas), .b_cas_in(dut_bcas),
    .a_cas_out(cas_acas), .b_cas_out(cas_bcas), .prod(cas_p)
  );

  for (genvar g = 0; g < 16; g++) begin : g_var
    mulel_top #(
      .IN_REG_A(g % 2 == 1), .IN_REG_B((g / 2) % 2 == 1),
      .PIPE_REG((g / 4) % 2 == 1), .OUT_REG((g / 8) % 2 == 1)
    ) u_var (
      .clk(clk), .ce(ce), .rst(rst), .a_in(a_i), .a_sign(sa_i), .b_in(b_i),
      .b_sign(sb_i), .a_cas_in(8'h00), .b_cas_in(8'h00),
      .a_cas_out(pca[g]), .b_cas_out(pcb[g]), .prod(pv[g])
    );
  end

  function automatic logic [15:0] ref_mul(input logic [7:0] a, input logic sa,
                                          input logic [7:0] b, input logic sb);
    int va, vb, r;
    va = (sa && a >= 8'd128) ? int'(a) - 256 : int'(a);
    vb = (sb && b >= 8'd128) ? int'(b) - 256 : int'(b);
    r  = va * vb;
    return r[15:0];
  endfunction

  function automatic logic [15:0] exp_at(input int ia, input int ib);
    logic [7:0] a, b;
    logic sa, sb;
    a = 8'h00; sa = 1'b0; b = 8'h00; sb = 1'b0;
    if (ia >= 0) begin a = VEC[ia][15:8]; sa = VEC[ia][17]; end
    if (ib >= 0) begin b = VEC[ib][7:0];  sb = VEC[ib][16]; end
    return ref_mul(a, sa, b, sb);
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    ce = 4'hF; rst = 4'hF; a_i = 8'h00; b_i = 8'h00; sa_i = 1'b0; sb_i = 1'b0;
    repeat (3) @(negedge clk);
    rst = 4'h0;
    #1;
    chk("R8 reset prod", dut_p, 16'h0000);
    chk("R8 reset cascade", {dut_acas, dut_bcas}, 16'h0000);

    // Table walk: R1 R2 R3 over every stage combination, R4 through the chain.
    for (int j = 0; j < NV; j++) begin
      @(negedge clk);
      {sa_i, sb_i, a_i, b_i} = VEC[j];
      #1;
      for (int g = 0; g < 16; g++) begin
        int tl, da, db;
        tl = (g / 4) % 2 + (g / 8) % 2;
        da = g % 2 + tl;
        db = (g / 2) % 2 + tl;
        chk($sformatf("R1 R2 R3 variant %0d row %0d", g, j), pv[g], exp_at(j - da, j - db));
      end
      chk($sformatf("R1 R2 full pipe row %0d", j), dut_p, exp_at(j - 3, j - 3));
      if (j >= 4)
        chk($sformatf("R4 cascade product row %0d", j), cas_p,
            ref_mul(VEC[j-4][15:8], 1'b0, VEC[j-4][7:0], 1'b0));
      else
        chk($sformatf("R4 cascade product row %0d", j), cas_p, 16'h0000);
    end

    // R5: cascade outputs
    @(negedge clk);
    a_i = 8'h5A; b_i = 8'h3C; sa_i = 1'b0; sb_i = 1'b0;
    #1;
    chk("R5 bypassed cascade follows source", {pca[0], pcb[0]}, 16'h5A3C);
    @(negedge clk); #1;
    chk("R5 cascade shows stored operand", {dut_acas, dut_bcas}, 16'h5A3C);
    repeat (4) @(negedge clk);
    #1;
    chk("R4 cascade settled", cas_p, 16'h1518);

    // R6: drop enable line 2 only
    @(negedge clk);
    ce = 4'b1011; a_i = 8'h11; b_i = 8'h02;
    repeat (4) begin
      @(negedge clk); #1;
      chk("R6 unselected group holds", cas_p, 16'h1518);
    end
    chk("R6 other enable line runs", dut_p, 16'h0022);

    // R7: reset line 3 clears even with enable low
    @(negedge clk);
    rst = 4'b1000;
    @(negedge clk); #1;
    chk("R7 reset over enable", cas_p, 16'h0000);
    chk("R7 reset cascade", {cas_acas, cas_bcas}, 16'h0000);
    chk("R7 other reset line ignored", dut_p, 16'h0022);
    rst = 4'b0000;

    // R8: reset line 0 on the full element
    @(negedge clk);
    rst = 4'b0001;
    @(negedge clk); #1;
    chk("R8 reset clears prod", dut_p, 16'h0000);
    chk("R8 reset clears cascade", {dut_acas, dut_bcas}, 16'h0000);
    rst = 4'b0000; ce = 4'hF;
    repeat (6) @(negedge clk);
    #1;
    chk("R4 cascade refill", cas_p, 16'h0022);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule